// File: doc/BRIEF.md
# Bus Activity Monitor Channel

This block watches one stream of bus events and turns it into a per-period activity figure. Each event pulse adds a programmable weight to a raw counter. At the end of every sampling period the accumulated value becomes the period count, the counter restarts, and an exponential moving average of the period counts is updated. The average can be seeded before counting starts and read back at any time.

The period count is compared against an upper and a lower watermark. A breach must repeat for a programmable number of back-to-back periods before it is recorded. The updated average is compared against its own pair of watermarks, and each of these is recorded at once. Recorded events sit in a write-one-to-clear status register. A level interrupt is raised for every status bit whose enable is set. Software programs the block through a simple 32-bit register port, with a write strobe, separate write and read addresses, and a combinational read.

Top module: `actmon_channel`

## Requirements
- R1: After reset every register reads 0 and `irq` and `periodTick` are low.
- R2: With control bit 31 (channel on) and bit 18 (periodic) both set, `periodTick` is high for one cycle in every PERIOD+1 cycles, where PERIOD is the register at 0x28. If either bit is clear, no tick occurs and event pulses change nothing.
- R3: Each cycle with `eventPulse` high adds the weight register (0x18) to the raw count. An event in the tick cycle belongs to the period that is ending. The count restarts from zero in each period.
- R4: At each period end the average becomes avg - (avg >> (K+1)) + (count >> (K+1)), with truncation. K is control bits 12:10. The average reads back at 0x20.
- R5: A write to 0x0C loads the average with the written value at once.
- R6: A period count strictly above the upper watermark (0x04) is a breach. When the number of consecutive breaching periods reaches N+1, status bit 31 is set, where N is control bits 28:26. The run count restarts after a non-breaching period and after it fires.
- R7: A period count strictly below the lower watermark (0x08) is a breach. After N+1 consecutive breaching periods status bit 30 is set, where N is control bits 25:23. The run count restarts in the same way as in R6.
- R8: An updated average strictly above 0x10 sets status bit 29. An updated average strictly below 0x14 sets status bit 28.
- R9: Writing the status register (0x24) clears the bits written as one and leaves the others. Writing all ones clears every flag.
- R10: `irq` is the OR of four terms: status 31 AND control 30, status 30 AND control 29, status 29 AND control 21, status 28 AND control 20. Clearing an enable drops `irq` but leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write byte address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 8 | Register read byte address |
| rdData | output | 32 | Combinational read data |
| eventPulse | input | 1 | One bus event per high cycle |
| periodTick | output | 1 | High in the last cycle of each sampling period |
| irq | output | 1 | Level interrupt |

## Verification
The hardest behaviour to reach from the ports is the consecutive-breach logic. It only shows up after a series of whole periods whose counts stay on one side of a watermark. A run that one quiet period interrupts must not fire. The bench therefore locks its stimulus to `periodTick` and places an exact number of event pulses inside each period. Its sequences break a breach run before it completes, then finish a run, then build the three-period lower run from a fresh start. A reference model follows the average and the run counters period by period, and the scoreboard compares the average and the interrupt after every tick.

// File: rtl/actmon_pkg.sv
package actmon_pkg;

  // register byte offsets
  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_UP_WM   = 8'h04;
  localparam logic [7:0] OFF_LO_WM   = 8'h08;
  localparam logic [7:0] OFF_INIT    = 8'h0C;
  localparam logic [7:0] OFF_AVG_UP  = 8'h10;
  localparam logic [7:0] OFF_AVG_LO  = 8'h14;
  localparam logic [7:0] OFF_WEIGHT  = 8'h18;
  localparam logic [7:0] OFF_AVG     = 8'h20;
  localparam logic [7:0] OFF_STATUS  = 8'h24;
  localparam logic [7:0] OFF_PERIOD  = 8'h28;

  // control word bit positions
  localparam int CTL_K_LSB       = 10;
  localparam int CTL_PERIODIC    = 18;
  localparam int CTL_AVG_LO_EN   = 20;
  localparam int CTL_AVG_UP_EN   = 21;
  localparam int CTL_LO_N_LSB    = 23;
  localparam int CTL_UP_N_LSB    = 26;
  localparam int CTL_LO_EN       = 29;
  localparam int CTL_UP_EN       = 30;
  localparam int CTL_CHAN_EN     = 31;

  // status vector index: [3]=bit31 upper run, [2]=bit30 lower run,
  // [1]=bit29 average above, [0]=bit28 average below
  localparam int STAT_W = 4;

  typedef struct packed {
    logic active;
    logic periodEnd;
    logic seedAvg;
  } ctlStrobe_t;

  typedef struct packed {
    logic upFire;
    logic loFire;
    logic avgAbove;
    logic avgBelow;
  } dpEvent_t;

endpackage

// File: rtl/actmon_datapath.sv
module actmon_datapath
  import actmon_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 3,
  parameter int K_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic               eventPulse,
  input  logic [DATA_W-1:0]  weight,
  input  logic [DATA_W-1:0]  upWm,
  input  logic [DATA_W-1:0]  loWm,
  input  logic [DATA_W-1:0]  avgUpWm,
  input  logic [DATA_W-1:0]  avgLoWm,
  input  logic [DATA_W-1:0]  seedVal,
  input  logic [K_W-1:0]     kExp,
  input  logic [FIELD_W-1:0] upN,
  input  logic [FIELD_W-1:0] loN,
  output logic [DATA_W-1:0]  avgValue,
  output dpEvent_t           events
);

  localparam int SHIFT_W = K_W + 1;

  logic [DATA_W-1:0]  rawCount;
  logic [DATA_W-1:0]  countNext;
  logic [DATA_W-1:0]  avgQ;
  logic [DATA_W-1:0]  newAvg;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [FIELD_W-1:0] upRun;
  logic [FIELD_W-1:0] loRun;
  logic               upBreach;
  logic               loBreach;

  assign countNext = eventPulse ? rawCount + weight : rawCount;
  assign shiftAmt  = {1'b0, kExp} + {{K_W{1'b0}}, 1'b1};
  assign newAvg    = avgQ - (avgQ >> shiftAmt) + (countNext >> shiftAmt);
  assign upBreach  = countNext > upWm;
  assign loBreach  = countNext < loWm;

  always_comb begin
    events          = '0;
    events.upFire   = strobe.periodEnd && upBreach && (upRun == upN);
    events.loFire   = strobe.periodEnd && loBreach && (loRun == loN);
    events.avgAbove = strobe.periodEnd && (newAvg > avgUpWm);
    events.avgBelow = strobe.periodEnd && (newAvg < avgLoWm);
  end

  // raw weighted event counter
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.active || strobe.periodEnd) begin
      rawCount <= '0;
    end else begin
      rawCount <= countNext;
    end
  end

  // moving average
  always_ff @(posedge clk) begin
    if (!rstN) begin
      avgQ <= '0;
    end else if (strobe.seedAvg) begin
      avgQ <= seedVal;
    end else if (strobe.periodEnd) begin
      avgQ <= newAvg;
    end
  end

  // consecutive breach run counters
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.active) begin
      upRun <= '0;
      loRun <= '0;
    end else if (strobe.periodEnd) begin
      if (!upBreach || events.upFire) upRun <= '0;
      else                            upRun <= upRun + 1'b1;
      if (!loBreach || events.loFire) loRun <= '0;
      else                            loRun <= loRun + 1'b1;
    end
  end

  assign avgValue = avgQ;

  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.periodEnd && !strobe.seedAvg) |=> $stable(avgQ)); // R4
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |=> (rawCount == '0)); // R2
  AST_UP_FIRE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (events.upFire && strobe.active) |=> (upRun == '0)); // R6
  AST_LO_FIRE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (events.loFire && strobe.active) |=> (loRun == '0)); // R7

endmodule

// File: rtl/actmon_ctrl.sv
module actmon_ctrl
  import actmon_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int PERIOD_W = 16,
  parameter int FIELD_W  = 3,
  parameter int K_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  dpEvent_t           events,
  input  logic [DATA_W-1:0]  avgValue,
  output ctlStrobe_t         strobe,
  output logic [DATA_W-1:0]  weight,
  output logic [DATA_W-1:0]  upWm,
  output logic [DATA_W-1:0]  loWm,
  output logic [DATA_W-1:0]  avgUpWm,
  output logic [DATA_W-1:0]  avgLoWm,
  output logic [DATA_W-1:0]  seedVal,
  output logic [K_W-1:0]     kExp,
  output logic [FIELD_W-1:0] upN,
  output logic [FIELD_W-1:0] loN,
  output logic               periodTick,
  output logic               irq
);

  logic [DATA_W-1:0]   ctrlQ, upWmQ, loWmQ, initQ, avgUpQ, avgLoQ, weightQ;
  logic [PERIOD_W-1:0] periodLenQ;
  logic [PERIOD_W-1:0] periodCntQ;
  logic [STAT_W-1:0]   statusQ;
  logic [STAT_W-1:0]   setVec;
  logic [STAT_W-1:0]   clrVec;
  logic [STAT_W-1:0]   enVec;
  logic                active;
  logic                periodEnd;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ      <= '0;
      upWmQ      <= '0;
      loWmQ      <= '0;
      initQ      <= '0;
      avgUpQ     <= '0;
      avgLoQ     <= '0;
      weightQ    <= '0;
      periodLenQ <= '0;
    end else if (wrEn) begin
      if (hit(wrAddr, OFF_CTRL))   ctrlQ      <= wrData;
      if (hit(wrAddr, OFF_UP_WM))  upWmQ      <= wrData;
      if (hit(wrAddr, OFF_LO_WM))  loWmQ      <= wrData;
      if (hit(wrAddr, OFF_INIT))   initQ      <= wrData;
      if (hit(wrAddr, OFF_AVG_UP)) avgUpQ     <= wrData;
      if (hit(wrAddr, OFF_AVG_LO)) avgLoQ     <= wrData;
      if (hit(wrAddr, OFF_WEIGHT)) weightQ    <= wrData;
      if (hit(wrAddr, OFF_PERIOD)) periodLenQ <= wrData[PERIOD_W-1:0];
    end
  end

  // sampling period timer
  assign active    = ctrlQ[CTL_CHAN_EN] && ctrlQ[CTL_PERIODIC];
  assign periodEnd = active && (periodCntQ == periodLenQ);

  always_ff @(posedge clk) begin
    if (!rstN || !active || periodEnd) begin
      periodCntQ <= '0;
    end else begin
      periodCntQ <= periodCntQ + 1'b1;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.active    = active;
    strobe.periodEnd = periodEnd;
    strobe.seedAvg   = wrEn && hit(wrAddr, OFF_INIT);
  end

  // status, write-one-to-clear, new events win
  assign setVec = {events.upFire, events.loFire, events.avgAbove, events.avgBelow};
  assign clrVec = (wrEn && hit(wrAddr, OFF_STATUS)) ? wrData[DATA_W-1 -: STAT_W] : '0;
  assign enVec  = {ctrlQ[CTL_UP_EN], ctrlQ[CTL_LO_EN], ctrlQ[CTL_AVG_UP_EN], ctrlQ[CTL_AVG_LO_EN]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clrVec) | setVec;
    end
  end

  assign irq        = |(statusQ & enVec);
  assign periodTick = periodEnd;

  // read mux
  always_comb begin
    rdData = '0;
    if      (hit(rdAddr, OFF_CTRL))   rdData = ctrlQ;
    else if (hit(rdAddr, OFF_UP_WM))  rdData = upWmQ;
    else if (hit(rdAddr, OFF_LO_WM))  rdData = loWmQ;
    else if (hit(rdAddr, OFF_INIT))   rdData = initQ;
    else if (hit(rdAddr, OFF_AVG_UP)) rdData = avgUpQ;
    else if (hit(rdAddr, OFF_AVG_LO)) rdData = avgLoQ;
    else if (hit(rdAddr, OFF_WEIGHT)) rdData = weightQ;
    else if (hit(rdAddr, OFF_AVG))    rdData = avgValue;
    else if (hit(rdAddr, OFF_STATUS)) rdData[DATA_W-1 -: STAT_W] = statusQ;
    else if (hit(rdAddr, OFF_PERIOD)) rdData = DATA_W'(periodLenQ);
  end

  assign weight  = weightQ;
  assign upWm    = upWmQ;
  assign loWm    = loWmQ;
  assign avgUpWm = avgUpQ;
  assign avgLoWm = avgLoQ;
  assign seedVal = wrData;
  assign kExp    = ctrlQ[CTL_K_LSB +: K_W];
  assign upN     = ctrlQ[CTL_UP_N_LSB +: FIELD_W];
  assign loN     = ctrlQ[CTL_LO_N_LSB +: FIELD_W];

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (periodTick && periodLenQ != '0 && $stable(ctrlQ)) |=> !periodTick); // R2
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != '0)); // R10
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec == '1 && setVec == '0) |=> (statusQ == '0)); // R9
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec == '0) |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R10

endmodule

// File: rtl/actmon_channel.sv
module actmon_channel
  import actmon_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int PERIOD_W = 16,
  parameter int FIELD_W  = 3,
  parameter int K_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              eventPulse,
  output logic              periodTick,
  output logic              irq
);

  ctlStrobe_t         strobe;
  dpEvent_t           events;
  logic [DATA_W-1:0]  weight, upWm, loWm, avgUpWm, avgLoWm, seedVal, avgValue;
  logic [K_W-1:0]     kExp;
  logic [FIELD_W-1:0] upN, loN;

  actmon_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W),
    .FIELD_W(FIELD_W), .K_W(K_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .events(events), .avgValue(avgValue),
    .strobe(strobe), .weight(weight), .upWm(upWm), .loWm(loWm),
    .avgUpWm(avgUpWm), .avgLoWm(avgLoWm), .seedVal(seedVal), .kExp(kExp),
    .upN(upN), .loN(loN), .periodTick(periodTick), .irq(irq)
  );

  actmon_datapath #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .K_W(K_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eventPulse(eventPulse),
    .weight(weight), .upWm(upWm), .loWm(loWm), .avgUpWm(avgUpWm),
    .avgLoWm(avgLoWm), .seedVal(seedVal), .kExp(kExp), .upN(upN), .loN(loN),
    .avgValue(avgValue), .events(events)
  );

endmodule

// File: tb/test_actmon_channel.sv
module test_actmon_channel;

  localparam logic [7:0] A_CTRL = 8'h00, A_UP = 8'h04, A_LO = 8'h08, A_INIT = 8'h0C,
                         A_AUP = 8'h10, A_ALO = 8'h14, A_WT = 8'h18, A_AVG = 8'h20,
                         A_STAT = 8'h24, A_PER = 8'h28;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        eventPulse = 1'b0;
  logic        periodTick;
  logic        irq;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] avg; logic irq; } exp_t;
  exp_t expQ[$];

  // reference model state
  logic [31:0] mAvg, mWt, mUp, mLo, mAUp, mALo;
  int          mK, mUpN, mLoN, mUpRun, mLoRun;
  logic [3:0]  mStat, mEn;

  always #2 clk = ~clk;

  actmon_channel i_actmon_channel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .eventPulse(eventPulse),
    .periodTick(periodTick), .irq(irq)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    rdAddr = a;
    #1 d = rdData;
    rdAddr = A_AVG;
  endtask

  function automatic logic [31:0] ctrlWord(int k, int upN, int loN, logic [3:0] en, logic on);
    logic [31:0] w = '0;
    w[31] = on; w[18] = 1'b1;
    w[12:10] = 3'(k); w[28:26] = 3'(upN); w[25:23] = 3'(loN);
    w[30] = en[3]; w[29] = en[2]; w[21] = en[1]; w[20] = en[0];
    return w;
  endfunction

  // model one period and push the expected result
  task automatic modelPeriod(input int c);
    logic [31:0] cnt, newA;
    int s;
    exp_t e;
    cnt = 32'(c) * mWt;
    s = mK + 1;
    newA = mAvg - (mAvg >> s) + (cnt >> s);
    if (cnt > mUp) begin
      if (mUpRun == mUpN) begin mStat[3] = 1'b1; mUpRun = 0; end
      else mUpRun++;
    end else mUpRun = 0;
    if (cnt < mLo) begin
      if (mLoRun == mLoN) begin mStat[2] = 1'b1; mLoRun = 0; end
      else mLoRun++;
    end else mLoRun = 0;
    if (newA > mAUp) mStat[1] = 1'b1;
    if (newA < mALo) mStat[0] = 1'b1;
    mAvg = newA;
    e.avg = newA;
    e.irq = |(mStat & mEn);
    expQ.push_back(e);
  endtask

  // driver: called at a negedge where periodTick is high
  task automatic playPeriod(input int c);
    modelPeriod(c);
    @(negedge clk);
    for (int i = 0; i < c; i++) begin
      eventPulse = 1'b1;
      @(negedge clk);
    end
    eventPulse = 1'b0;
    while (!periodTick) @(negedge clk);
  endtask

  task automatic startPhase(input logic [31:0] ctrl);
    mUpRun = 0; mLoRun = 0;
    modelPeriod(0);
    writeReg(A_CTRL, ctrl);
    while (!periodTick) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && periodTick) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected period end", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(rdData == e.avg, "R4 average after period", rdData, e.avg);
          check(irq == e.irq, "R6/R10 irq after period", {31'd0, irq}, {31'd0, e.irq});
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int gap;
    int seq1[12] = '{6, 3, 6, 6, 8, 1, 1, 2, 1, 1, 1, 4};
    int seq2[5]  = '{8, 0, 0, 8, 8};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rdAddr = A_AVG;
    @(negedge clk);

    // R1 reset state
    readReg(A_CTRL, d);  check(d == 0, "R1 control after reset", d, 0);
    readReg(A_AVG, d);   check(d == 0, "R1 average after reset", d, 0);
    readReg(A_STAT, d);  check(d == 0, "R1 status after reset", d, 0);
    check(irq == 0 && periodTick == 0, "R1 outputs after reset", {30'd0, irq, periodTick}, 0);

    // configuration
    mWt = 100; mUp = 500; mLo = 150; mAUp = 450; mALo = 120;
    writeReg(A_WT, mWt); writeReg(A_UP, mUp); writeReg(A_LO, mLo);
    writeReg(A_AUP, mAUp); writeReg(A_ALO, mALo); writeReg(A_PER, 32'd9);

    // R5 seed
    writeReg(A_INIT, 32'd300);
    readReg(A_AVG, d); check(d == 300, "R5 seeded average", d, 300);
    mAvg = 300;

    // R2 disabled: periodic bit clear, events ignored, no tick
    writeReg(A_CTRL, 32'h8000_0000);
    gap = 0;
    for (int i = 0; i < 30; i++) begin
      eventPulse = 1'b1;
      @(negedge clk);
      if (periodTick) gap++;
    end
    eventPulse = 1'b0;
    check(gap == 0, "R2 no tick while periodic off", gap, 0);
    readReg(A_AVG, d); check(d == 300, "R2 events ignored while off", d, 300);

    // phase A: K=0, upper run N=1 (fires on 2nd), lower run N=2 (fires on 3rd)
    mK = 0; mUpN = 1; mLoN = 2; mStat = '0; mEn = 4'b1000;
    startPhase(ctrlWord(mK, mUpN, mLoN, mEn, 1'b1));
    // R2 period length
    gap = 0;
    @(negedge clk);
    gap = 1;
    while (!periodTick) begin @(negedge clk); gap++; end
    check(gap == 10, "R2 period length", gap, 10);
    modelPeriod(0);   // the measured period carried no events
    for (int i = 0; i < 12; i++) playPeriod(seq1[i]);   // R3 R6 R7 R8
    @(negedge clk); @(negedge clk);
    readReg(A_STAT, d);
    check(d[31:28] == mStat, "R6/R7/R8 status after sequence", {28'd0, d[31:28]}, {28'd0, mStat});
    check(mStat[3] && mStat[2], "R6/R7 runs completed", {28'd0, mStat}, 32'hC);

    // R10 enable cleared: irq drops, status kept
    writeReg(A_CTRL, 32'h0);
    check(irq == 0, "R10 irq masked", {31'd0, irq}, 0);
    readReg(A_STAT, d);
    check(d[31:28] == mStat, "R10 status kept when masked", {28'd0, d[31:28]}, {28'd0, mStat});

    // R9 partial then full clear
    writeReg(A_STAT, 32'h8000_0000);
    mStat[3] = 1'b0;
    readReg(A_STAT, d);
    check(d[31:28] == mStat, "R9 partial clear", {28'd0, d[31:28]}, {28'd0, mStat});
    writeReg(A_STAT, 32'hFFFF_FFFF);
    mStat = '0;
    readReg(A_STAT, d);
    check(d == 0, "R9 full clear", d, 0);

    // phase B: K=5 (shift 6), average-above interrupt only
    mWt = 1000; mK = 5; mEn = 4'b0010; mAUp = 4000; mALo = 0;
    writeReg(A_WT, mWt); writeReg(A_AUP, mAUp); writeReg(A_ALO, mALo);
    writeReg(A_INIT, 32'd5000); mAvg = 5000;
    readReg(A_AVG, d); check(d == 5000, "R5 reseed average", d, 5000);
    startPhase(ctrlWord(mK, mUpN, mLoN, mEn, 1'b1));
    for (int i = 0; i < 5; i++) playPeriod(seq2[i]);   // R4 with K=5
    @(negedge clk); @(negedge clk);
    writeReg(A_CTRL, 32'h0);
    check(expQ.size() == 0, "R4 every period observed", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule